// File: doc/BRIEF.md
# Compare-Output Waveform Pin Unit

This block holds the single waveform bit produced by an 8-bit timer's compare logic and routes it onto a general-purpose I/O pin. The timer supplies one-cycle event pulses: a compare match, the counter reaching bottom, and the counting direction in phase-correct operation. It also supplies the current waveform kind. A two-bit action field picks what each event does to the stored bit. The field is applied unbuffered, so each event uses the value present in its own cycle.

Software can force the configured action with a one-cycle strobe in the two non-PWM kinds. The strobe is ignored in the PWM kinds. Software can also load the stored bit directly. This lets the level be set before the pin override is switched on, and the bit keeps its value when the waveform kind changes. Whenever the action field is nonzero, the pin's output value comes from the stored bit instead of the port data bit. The pin's drive enable always follows the port direction bit, whatever the action field and waveform kind.

Top module: `cmp_out_pin`

## Requirements
- R1: After reset the stored bit `ocState` is 0. With `cmpMode` = 00, `pinOut` then equals `portData`.
- R2: With `cmpMode` = 00, no match, bottom or force event changes `ocState`.
- R3: When `cmpMode` is nonzero, `pinOut` equals `ocState`; when it is 00, `pinOut` equals `portData`. This holds for every `wave` value.
- R4: `pinOe` always equals `portDir`, whatever `cmpMode` and `wave` are.
- R5: In normal (`wave` = 00) and clear-on-match (`wave` = 01) kinds, a match with `cmpMode` 01 toggles `ocState`, 10 clears it and 11 sets it. The new value is visible after the next rising clock edge.
- R6: In kinds 00 and 01, `forceStrobe` applies the same action as a match. If the strobe and a match fall in the same cycle, the action is applied once only (a toggle flips the bit once).
- R7: In the PWM kinds (`wave` = 10 or 11), `forceStrobe` has no effect on `ocState`.
- R8: In fast PWM (`wave` = 10), `cmpMode` 10 clears on match and sets on bottom, and 11 does the opposite. 01 does nothing. If a match and a bottom fall in the same cycle, the match action wins.
- R9: In phase-correct PWM (`wave` = 11), a match while counting up (`countDown` = 0) clears for 10 and sets for 11. A match while counting down does the opposite. 01 does nothing, and bottom pulses are ignored.
- R10: The action is taken from the `cmpMode` value present in the event's cycle, even if it was changed in that same cycle.
- R11: With no events, `ocState` keeps its value across any change of `wave`.
- R12: `presetWe` loads `presetVal` into `ocState` at the next edge. It overrides any event in the same cycle and works with `cmpMode` = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wave | input | 2 | Waveform kind: 00 normal, 01 clear-on-match, 10 fast PWM, 11 phase-correct PWM |
| cmpMode | input | 2 | Compare action field, unbuffered |
| matchPulse | input | 1 | Compare match event, one cycle |
| bottomPulse | input | 1 | Counter at bottom event, one cycle |
| countDown | input | 1 | Counter is counting down (phase-correct) |
| forceStrobe | input | 1 | Force the match action, one cycle |
| presetWe | input | 1 | Load presetVal into the stored bit |
| presetVal | input | 1 | Value to load |
| portData | input | 1 | Port data bit |
| portDir | input | 1 | Port direction bit, 1 = output |
| pinOut | output | 1 | Pin output value |
| pinOe | output | 1 | Pin output enable |
| ocState | output | 1 | Stored compare-output bit |

## Verification
Several events can land in the same cycle: a forced strobe with a real match, a match with a bottom pulse, and a software preset with any event. The bench sweeps every combination of event bits, waveform kind, action field and starting level. Each combination is started from a preset level, and all its events are driven in one cycle. The next stored bit is compared against an arithmetic model built from the priority rules: preset first, then match over bottom, and force merged with match so it is applied once. The pin value and enable are also checked against random port bits in every step.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

  typedef enum logic [1:0] {
    WAVE_NORMAL = 2'b00,
    WAVE_CTC    = 2'b01,
    WAVE_FAST   = 2'b10,
    WAVE_PHASE  = 2'b11
  } waveKind_t;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmpAct_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic set;
    logic clr;
    logic tog;
    logic override;
  } ocStrobe_t;

endpackage

// File: rtl/cmp_out_ctrl.sv
module cmp_out_ctrl
  import cmp_out_pkg::*;
(
  input  logic [1:0] wave,
  input  logic [1:0] cmpMode,
  input  logic       matchPulse,
  input  logic       bottomPulse,
  input  logic       countDown,
  input  logic       forceStrobe,
  input  logic       presetWe,
  output ocStrobe_t  strobe
);

  waveKind_t waveK;
  cmpAct_t   actK;
  logic      nonPwmHit;
  logic      setOnMatch;

  assign waveK = waveKind_t'(wave);
  assign actK  = cmpAct_t'(cmpMode);

  // force merged with match so a coincident pair acts once
  assign nonPwmHit = matchPulse | forceStrobe;

  // In phase-correct, the down-count match inverts the up-count action
  assign setOnMatch = (waveK == WAVE_PHASE) ? ((actK == ACT_SET) ^ countDown)
                                            : (actK == ACT_SET);

  always_comb begin
    strobe          = '0;
    strobe.override = (cmpMode != 2'b00);
    if (presetWe) begin
      strobe.load = 1'b1;
    end else begin
      unique case (waveK)
        WAVE_NORMAL, WAVE_CTC: begin
          if (nonPwmHit) begin
            unique case (actK)
              ACT_TOGGLE: strobe.tog = 1'b1;
              ACT_CLEAR:  strobe.clr = 1'b1;
              ACT_SET:    strobe.set = 1'b1;
              default:    ;
            endcase
          end
        end
        WAVE_FAST: begin
          if (actK == ACT_CLEAR || actK == ACT_SET) begin
            if (matchPulse) begin
              strobe.set = setOnMatch;
              strobe.clr = ~setOnMatch;
            end else if (bottomPulse) begin
              strobe.set = ~setOnMatch;
              strobe.clr = setOnMatch;
            end
          end
        end
        WAVE_PHASE: begin
          if ((actK == ACT_CLEAR || actK == ACT_SET) && matchPulse) begin
            strobe.set = setOnMatch;
            strobe.clr = ~setOnMatch;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmp_out_dp.sv
module cmp_out_dp
  import cmp_out_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  ocStrobe_t strobe,
  input  logic      presetVal,
  input  logic      portData,
  input  logic      portDir,
  output logic      pinOut,
  output logic      pinOe,
  output logic      ocState
);

  logic ocReg;

  always_ff @(posedge clk) begin
    if (!rstN)            ocReg <= RESET_LEVEL;
    else if (strobe.load) ocReg <= presetVal;
    else if (strobe.set)  ocReg <= 1'b1;
    else if (strobe.clr)  ocReg <= 1'b0;
    else if (strobe.tog)  ocReg <= ~ocReg;
  end

  assign pinOut  = strobe.override ? ocReg : portData;
  assign pinOe   = portDir;
  assign ocState = ocReg;

endmodule

// File: rtl/cmp_out_pin.sv
module cmp_out_pin
  import cmp_out_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] wave,
  input  logic [1:0] cmpMode,
  input  logic       matchPulse,
  input  logic       bottomPulse,
  input  logic       countDown,
  input  logic       forceStrobe,
  input  logic       presetWe,
  input  logic       presetVal,
  input  logic       portData,
  input  logic       portDir,
  output logic       pinOut,
  output logic       pinOe,
  output logic       ocState
);

  ocStrobe_t strobe;

  cmp_out_ctrl ctrl_i (
    .wave       (wave),
    .cmpMode    (cmpMode),
    .matchPulse (matchPulse),
    .bottomPulse(bottomPulse),
    .countDown  (countDown),
    .forceStrobe(forceStrobe),
    .presetWe   (presetWe),
    .strobe     (strobe)
  );

  cmp_out_dp #(.RESET_LEVEL(RESET_LEVEL)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .presetVal(presetVal),
    .portData (portData),
    .portDir  (portDir),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .ocState  (ocState)
  );

endmodule

// File: rtl/cmp_out_chk.sv
module cmp_out_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] wave,
  input logic [1:0] cmpMode,
  input logic       matchPulse,
  input logic       bottomPulse,
  input logic       forceStrobe,
  input logic       presetWe,
  input logic       presetVal,
  input logic       ocState
);

  // R2
  p_mode_off_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMode == 2'b00 && !presetWe) |=> (ocState == $past(ocState)));

  // R12
  p_preset_load_r12: assert property (@(posedge clk) disable iff (!rstN)
    presetWe |=> (ocState == $past(presetVal)));

  // R7
  p_force_pwm_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wave[1] && forceStrobe && !matchPulse && !bottomPulse && !presetWe)
      |=> (ocState == $past(ocState)));

  // R5 and R6: toggle flips exactly once
  p_toggle_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wave[1] && cmpMode == 2'b01 && (matchPulse || forceStrobe) && !presetWe)
      |=> (ocState != $past(ocState)));

  // R9
  p_phase_bottom_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wave == 2'b11 && bottomPulse && !matchPulse && !presetWe)
      |=> (ocState == $past(ocState)));

endmodule

bind cmp_out_pin cmp_out_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .wave       (wave),
  .cmpMode    (cmpMode),
  .matchPulse (matchPulse),
  .bottomPulse(bottomPulse),
  .forceStrobe(forceStrobe),
  .presetWe   (presetWe),
  .presetVal  (presetVal),
  .ocState    (ocState)
);

// File: tb/cmp_out_pin_tb.sv
module cmp_out_pin_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] wave = 2'b00;
  logic [1:0] cmpMode = 2'b00;
  logic       matchPulse = 1'b0;
  logic       bottomPulse = 1'b0;
  logic       countDown = 1'b0;
  logic       forceStrobe = 1'b0;
  logic       presetWe = 1'b0;
  logic       presetVal = 1'b0;
  logic       portData = 1'b0;
  logic       portDir = 1'b0;
  logic       pinOut;
  logic       pinOe;
  logic       ocState;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cmp_out_pin dut_i (
    .clk(clk), .rstN(rstN), .wave(wave), .cmpMode(cmpMode),
    .matchPulse(matchPulse), .bottomPulse(bottomPulse), .countDown(countDown),
    .forceStrobe(forceStrobe), .presetWe(presetWe), .presetVal(presetVal),
    .portData(portData), .portDir(portDir),
    .pinOut(pinOut), .pinOe(pinOe), .ocState(ocState)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Model from the requirements
  function automatic logic modelNext(input logic st, input logic [1:0] w,
      input logic [1:0] m, input logic mt, input logic bt, input logic f,
      input logic dn);
    logic r;
    r = st;
    if (m == 2'b00) return st;                         // R2
    if (w[1] == 1'b0) begin                            // R5 R6
      if (mt || f) r = (m == 2'b01) ? ~st : (m == 2'b11);
    end else if (w == 2'b10) begin                     // R8
      if (m != 2'b01) begin
        if (mt)      r = (m == 2'b11);
        else if (bt) r = (m == 2'b10);
      end
    end else begin                                     // R9
      if (m != 2'b01 && mt) r = (m == 2'b11) ^ dn;
    end
    return r;
  endfunction

  function automatic string reqTag(input logic [1:0] w, input logic [1:0] m,
      input logic f);
    if (m == 2'b00) return "R2";
    if (w[1] && f)  return "R7";
    if (!w[1] && f) return "R6";
    if (w == 2'b10) return "R8";
    if (w == 2'b11) return "R9";
    return "R5";
  endfunction

  task automatic checkPins(input string ctx);
    check({"R4 ", ctx}, pinOe, portDir);
    check({"R3 ", ctx}, pinOut, (cmpMode != 2'b00) ? ocState : portData);
  endtask

  task automatic idleInputs();
    matchPulse = 0; bottomPulse = 0; forceStrobe = 0; presetWe = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    portData = 1'b1; portDir = 1'b1;
    #1;
    check("R1 reset state", ocState, 1'b0);
    check("R1 pin after reset", pinOut, 1'b1);
    checkPins("after reset");

    // Exhaustive sweep of event combinations
    for (int st = 0; st < 2; st++) begin
      for (int w = 0; w < 4; w++) begin
        for (int m = 0; m < 4; m++) begin
          for (int ev = 0; ev < 16; ev++) begin
            logic exp;
            @(negedge clk);
            idleInputs();
            presetWe = 1; presetVal = st[0];
            wave = w[1:0]; cmpMode = 2'b00;
            @(negedge clk);
            check("R12 preset", ocState, st[0]);
            presetWe = 0;
            cmpMode = m[1:0];                          // R10: written this cycle
            matchPulse = ev[0]; bottomPulse = ev[1];
            forceStrobe = ev[2]; countDown = ev[3];
            portData = $urandom_range(0, 1);
            portDir  = $urandom_range(0, 1);
            #1;
            checkPins("before event");
            exp = modelNext(st[0], w[1:0], m[1:0], ev[0], ev[1], ev[2], ev[3]);
            @(negedge clk);
            idleInputs();
            check(reqTag(w[1:0], m[1:0], ev[2]), ocState, exp);
            checkPins("after event");
          end
        end
      end
    end

    // R12: preset beats a coincident match
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      wave = w[1:0]; cmpMode = 2'b11; presetWe = 1; presetVal = 0;
      matchPulse = 1; forceStrobe = 1; bottomPulse = 1;
      @(negedge clk);
      idleInputs();
      check("R12 preset over event", ocState, 1'b0);
    end

    // R10: mode changed in the match cycle decides the action
    @(negedge clk);
    wave = 2'b00; cmpMode = 2'b11; matchPulse = 1;
    @(negedge clk);
    check("R10 set under 11", ocState, 1'b1);
    matchPulse = 0;
    @(negedge clk);
    cmpMode = 2'b10; matchPulse = 1;
    @(negedge clk);
    matchPulse = 0;
    check("R10 clear under new mode", ocState, 1'b0);

    // R11: held across waveform kind changes
    @(negedge clk);
    presetWe = 1; presetVal = 1;
    @(negedge clk);
    presetWe = 0;
    for (int w = 0; w < 4; w++) begin
      wave = w[1:0];
      @(negedge clk);
      check("R11 hold across kinds", ocState, 1'b1);
    end

    // R1: reset again from a set state
    rstN = 0;
    @(negedge clk);
    rstN = 1; cmpMode = 2'b00; portData = 0;
    #1;
    check("R1 reset clears", ocState, 1'b0);
    check("R1 pin follows port", pinOut, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule